// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns single transfer requests from the internal side into cycles on an asynchronous external memory bus. The internal address space is 64 MB wide by default. The lowest 16 MB of it is cut into four equal 4 MB windows. Each window owns one device-select pin, and the external address carries the 22-bit offset inside that window. Each window has its own wait-state count and a polarity setting. A window can also be set to end its cycles on an external acknowledge instead of a fixed count. An acknowledge that never arrives ends in an abort with an error response.

The data bus is 16 bits wide, with two active-low byte-enable pins: one for the high lane and one for the low lane. The bus drops to 8 bits whenever the open-drain bus-width pin is low. Any outside device may pull that pin low, or the block may pull it low itself from a configuration bit. In 8-bit mode a halfword transfer becomes two byte cycles. The internal side sees one response after the second cycle. Halfword data is big-endian: the high byte belongs to the even address.

The sequencer has six states:
- IDLE accepts a request. It goes to STROBE when the address hits a window, and to REJECT when it does not.
- STROBE drives the select, the address and the strobes, and counts cycles. On completion it goes to FINISH. The exception is the first half of a split halfword, which goes to SPLIT instead. If the acknowledge timeout runs out, STROBE goes to ABORT.
- SPLIT is a one-cycle gap with the strobes released. It returns to STROBE for the odd byte.
- FINISH, ABORT and REJECT each give a one-cycle response and return to IDLE.

Top module: `ext_bus_ctrl`

## Requirements
- R1: An accepted address selects window `addr[23:22]`, drives only that select active while strobing, and puts `addr[21:0]` on the external address. A halfword access clears bit 0.
- R2: An address with any bit above bit 23 set gives `resp_done` and `resp_err` on the cycle after acceptance. No select or strobe becomes active.
- R3: In 16-bit mode the byte enables work as follows. A halfword drives `ext_be_n=2'b00` with the whole word on the data pins. A byte at an even address drives `ext_be_n=2'b10` (bit 0 low) with data on bits [15:8]. A byte at an odd address drives `ext_be_n=2'b01` with data on bits [7:0].
- R4: The bus is 8 bits wide when `ext_bw8_n` is low or `cfg_narrow` is 1. In that mode `ext_be_n` is `2'b01` and all data moves on bits [7:0]. `ext_bw8_pull` (1 = pull the pin low) follows `cfg_narrow`.
- R5: An 8-bit-mode halfword runs the even address first, carrying the high byte. One released cycle follows, then the odd address carrying the low byte. `resp_done` comes 2W+4 cycles after the request cycle.
- R6: With acknowledge mode off for its window, a strobe lasts W+1 cycles, where W is the window's 4-bit wait count. `resp_done` is high W+2 cycles after the request cycle, for one cycle.
- R7: With acknowledge mode on, the strobe holds until `ext_ack_n` is sampled low at a rising edge. That edge ends the cycle.
- R8: If the acknowledge stays high for 256 strobe cycles, `ext_abort_n` goes low for one cycle together with `resp_done` and `resp_err`. The next request then runs normally.
- R9: Select 0 is active low. Select i (i = 1..3) is active high when `cfg_sel_pol[i]` is 1 and active low otherwise. Inactive selects sit at the opposite level.
- R10: During reset and in IDLE, `ext_data_oe` is 0, `ext_data_o` is all ones, both strobes are high and `ext_abort_n` is high.
- R11: Read data is taken when each cycle completes. A byte read returns in `resp_rdata[7:0]` with the upper byte zero. A halfword read returns the even-address byte in [15:8].
- R12: A write drives `ext_we_n` low with `ext_data_oe` high. A read drives `ext_oe_n` low with `ext_data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer is in IDLE |
| req_addr | input | 26 | Internal byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error qualifier for `resp_done` |
| resp_rdata | output | 16 | Read data, valid with `resp_done` |
| cfg_wait | input | 16 | Four 4-bit wait counts, window i at [4i+3:4i] |
| cfg_ack_mode | input | 4 | Per window: end cycles on acknowledge |
| cfg_sel_pol | input | 3 | Polarity of selects 3..1, 1 = active high |
| cfg_narrow | input | 1 | Force 8-bit mode by pulling the width pin |
| ext_addr | output | 22 | External address |
| ext_data_o | output | 16 | Data out |
| ext_data_oe | output | 1 | Data output enable |
| ext_data_i | input | 16 | Data in |
| ext_be_n | output | 2 | Byte enables, bit 0 for [15:8], bit 1 for [7:0] |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_oe_n | output | 1 | Output-enable strobe, active low |
| ext_sel | output | 4 | Device selects |
| ext_ack_n | input | 1 | Transfer acknowledge, active low |
| ext_abort_n | output | 1 | Abort indication, active low |
| ext_bw8_n | input | 1 | Sensed level of the wired bus-width pin |
| ext_bw8_pull | output | 1 | Pull the bus-width pin low |

## Verification
The hardest situation to reach is the acknowledge timeout. It needs a window in acknowledge mode and an external device that keeps the acknowledge high through all 256 strobe cycles. The bench's device model has a programmable acknowledge delay, and a directed test sets it far beyond the limit. That test then checks the abort timing and that the following transfer completes. The two ways of entering 8-bit mode are also hard to reach together, since the width pin is shared. The vector table therefore alternates between pulling the pin from outside and setting the internal bit, and it also runs split halfword transfers in each.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_SPLIT,
        ST_FINISH,
        ST_ABORT,
        ST_REJECT
    } ebc_state_e;
endpackage

// File: rtl/ebc_decode.sv
module ebc_decode #(
    parameter int INT_AW = 26,
    parameter int EXT_AW = 22,
    parameter int NSEL   = 4,
    localparam int SEL_W = $clog2(NSEL),
    localparam int TOP   = EXT_AW + SEL_W
) (
    input  logic [INT_AW-1:EXT_AW] addr_hi,
    output logic                   hit,
    output logic [SEL_W-1:0]       sel_idx
);
    generate
        if (INT_AW > TOP) begin : g_range
            assign hit = (addr_hi[INT_AW-1:TOP] == '0);
        end else begin : g_full
            assign hit = 1'b1;
        end
    endgenerate

    assign sel_idx = addr_hi[TOP-1:EXT_AW];
endmodule

// File: rtl/ebc_selpins.sv
module ebc_selpins #(
    parameter int NSEL = 4
) (
    input  logic [NSEL-1:0] act,
    input  logic [NSEL-1:1] pol,
    output logic [NSEL-1:0] pins
);
    generate
        for (genvar i = 0; i < NSEL; i++) begin : g_pin
            if (i == 0) begin : g_fixed
                assign pins[i] = ~act[i];
            end else begin : g_prog
                assign pins[i] = pol[i] ? act[i] : ~act[i];
            end
        end
    endgenerate
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int EXT_AW    = 22,
    parameter int BYTE_W    = 8,
    parameter int NSEL      = 4,
    parameter int WS_W      = 4,
    parameter int ACK_LIMIT = 256,
    localparam int SEL_W    = $clog2(NSEL),
    localparam int DW       = 2 * BYTE_W,
    localparam int CNT_W    = $clog2(ACK_LIMIT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [EXT_AW-1:0]    req_addr,
    input  logic                 hit,
    input  logic [SEL_W-1:0]     sel_idx,
    input  logic                 req_write,
    input  logic                 req_half,
    input  logic [DW-1:0]        req_wdata,
    input  logic [NSEL*WS_W-1:0] cfg_wait,
    input  logic [NSEL-1:0]      cfg_ack_mode,
    input  logic                 narrow_now,
    input  logic                 ext_ack_n,
    input  logic [DW-1:0]        ext_data_i,
    output logic                 req_ready,
    output logic                 resp_done,
    output logic                 resp_err,
    output logic [DW-1:0]        resp_rdata,
    output logic [EXT_AW-1:0]    ext_addr,
    output logic [DW-1:0]        ext_data_o,
    output logic                 ext_data_oe,
    output logic [1:0]           ext_be_n,
    output logic                 ext_we_n,
    output logic                 ext_oe_n,
    output logic [NSEL-1:0]      sel_act,
    output logic                 ext_abort_n
);
    ebc_state_e          state_q, state_d;
    logic [EXT_AW-1:0]   addr_q;
    logic [SEL_W-1:0]    sel_q;
    logic                wr_q, hw_q, narrow_q, phase_q, useack_q;
    logic [DW-1:0]       wdata_q, rdata_q, rd_merge, lanes;
    logic [WS_W-1:0]     wait_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                strobing, strobe_end, timeout, accept;
    logic [BYTE_W-1:0]   cur_byte;

    assign strobing   = (state_q == ST_STROBE);
    assign accept     = (state_q == ST_IDLE) && req_valid && hit;
    assign strobe_end = useack_q ? ~ext_ack_n : (cnt_q == CNT_W'(wait_q));
    assign timeout    = useack_q && ext_ack_n && (cnt_q == CNT_W'(ACK_LIMIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = hit ? ST_STROBE : ST_REJECT;
            ST_STROBE: begin
                if (strobe_end)   state_d = (hw_q && narrow_q && !phase_q) ? ST_SPLIT : ST_FINISH;
                else if (timeout) state_d = ST_ABORT;
            end
            ST_SPLIT:  state_d = ST_STROBE;
            ST_FINISH, ST_ABORT, ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // read lane merge
    always_comb begin
        if (narrow_q) begin
            if (hw_q && !phase_q) rd_merge = {ext_data_i[BYTE_W-1:0], rdata_q[BYTE_W-1:0]};
            else                  rd_merge = {rdata_q[DW-1:BYTE_W], ext_data_i[BYTE_W-1:0]};
        end else if (hw_q) begin
            rd_merge = ext_data_i;
        end else if (addr_q[0]) begin
            rd_merge = {{BYTE_W{1'b0}}, ext_data_i[BYTE_W-1:0]};
        end else begin
            rd_merge = {{BYTE_W{1'b0}}, ext_data_i[DW-1:BYTE_W]};
        end
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            sel_q    <= '0;
            wr_q     <= 1'b0;
            hw_q     <= 1'b0;
            narrow_q <= 1'b0;
            phase_q  <= 1'b0;
            useack_q <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            wait_q   <= '0;
            cnt_q    <= '0;
        end else begin
            if (accept) begin
                addr_q   <= req_half ? {req_addr[EXT_AW-1:1], 1'b0} : req_addr;
                sel_q    <= sel_idx;
                wr_q     <= req_write;
                hw_q     <= req_half;
                narrow_q <= narrow_now;
                phase_q  <= 1'b0;
                useack_q <= cfg_ack_mode[sel_idx];
                wdata_q  <= req_wdata;
                rdata_q  <= '0;
                wait_q   <= cfg_wait[int'(sel_idx)*WS_W +: WS_W];
            end
            cnt_q <= (strobing && !strobe_end) ? cnt_q + 1'b1 : '0;
            if (strobing && strobe_end && !wr_q) rdata_q <= rd_merge;
            if (state_q == ST_SPLIT) phase_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cur_byte = (hw_q && !phase_q) ? wdata_q[DW-1:BYTE_W] : wdata_q[BYTE_W-1:0];
        if (narrow_q || !hw_q) lanes = {cur_byte, cur_byte};
        else                   lanes = wdata_q;

        req_ready   = (state_q == ST_IDLE);
        resp_done   = (state_q == ST_FINISH) || (state_q == ST_ABORT) || (state_q == ST_REJECT);
        resp_err    = (state_q == ST_ABORT) || (state_q == ST_REJECT);
        ext_abort_n = (state_q != ST_ABORT);
        resp_rdata  = rdata_q;
        ext_addr    = addr_q | {{(EXT_AW-1){1'b0}}, phase_q};
        ext_data_oe = strobing && wr_q;
        ext_data_o  = ext_data_oe ? lanes : '1;
        ext_we_n    = ~(strobing && wr_q);
        ext_oe_n    = ~(strobing && !wr_q);
        sel_act     = '0;
        if (strobing) sel_act[sel_q] = 1'b1;
        if (strobing ? narrow_q : narrow_now) ext_be_n = 2'b01;
        else if (!strobing)                   ext_be_n = 2'b11;
        else if (hw_q)                        ext_be_n = 2'b00;
        else if (addr_q[0])                   ext_be_n = 2'b01;
        else                                  ext_be_n = 2'b10;
    end

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !hit) |=>
            (resp_done && resp_err && sel_act == '0 && ext_we_n && ext_oe_n));

    assert_narrow_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ext_we_n || !ext_oe_n) && narrow_q) |-> (ext_be_n == 2'b01));

    assert_abort_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_abort_n |-> (resp_done && resp_err));

    assert_abort_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_abort_n) |-> ($past(ext_ack_n) && $past(!ext_oe_n || !ext_we_n)));

    assert_drive_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe |-> (!ext_we_n && ext_oe_n));

    assert_split_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPLIT) |=> (strobing && ext_addr[0]));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
    parameter int INT_AW    = 26,
    parameter int EXT_AW    = 22,
    parameter int BYTE_W    = 8,
    parameter int NSEL      = 4,
    parameter int WS_W      = 4,
    parameter int ACK_LIMIT = 256,
    localparam int DW       = 2 * BYTE_W,
    localparam int SEL_W    = $clog2(NSEL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [INT_AW-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_half,
    input  logic [DW-1:0]        req_wdata,
    output logic                 resp_done,
    output logic                 resp_err,
    output logic [DW-1:0]        resp_rdata,
    input  logic [NSEL*WS_W-1:0] cfg_wait,
    input  logic [NSEL-1:0]      cfg_ack_mode,
    input  logic [NSEL-1:1]      cfg_sel_pol,
    input  logic                 cfg_narrow,
    output logic [EXT_AW-1:0]    ext_addr,
    output logic [DW-1:0]        ext_data_o,
    output logic                 ext_data_oe,
    input  logic [DW-1:0]        ext_data_i,
    output logic [1:0]           ext_be_n,
    output logic                 ext_we_n,
    output logic                 ext_oe_n,
    output logic [NSEL-1:0]      ext_sel,
    input  logic                 ext_ack_n,
    output logic                 ext_abort_n,
    input  logic                 ext_bw8_n,
    output logic                 ext_bw8_pull
);
    logic             hit;
    logic [SEL_W-1:0] sel_idx;
    logic [NSEL-1:0]  sel_act;
    logic             narrow_now;

    assign narrow_now   = cfg_narrow | ~ext_bw8_n;
    assign ext_bw8_pull = cfg_narrow;

    ebc_decode #(.INT_AW(INT_AW), .EXT_AW(EXT_AW), .NSEL(NSEL)) u_decode (
        .addr_hi (req_addr[INT_AW-1:EXT_AW]),
        .hit     (hit),
        .sel_idx (sel_idx)
    );

    ebc_seq #(.EXT_AW(EXT_AW), .BYTE_W(BYTE_W), .NSEL(NSEL), .WS_W(WS_W),
              .ACK_LIMIT(ACK_LIMIT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr[EXT_AW-1:0]),
        .hit          (hit),
        .sel_idx      (sel_idx),
        .req_write    (req_write),
        .req_half     (req_half),
        .req_wdata    (req_wdata),
        .cfg_wait     (cfg_wait),
        .cfg_ack_mode (cfg_ack_mode),
        .narrow_now   (narrow_now),
        .ext_ack_n    (ext_ack_n),
        .ext_data_i   (ext_data_i),
        .req_ready    (req_ready),
        .resp_done    (resp_done),
        .resp_err     (resp_err),
        .resp_rdata   (resp_rdata),
        .ext_addr     (ext_addr),
        .ext_data_o   (ext_data_o),
        .ext_data_oe  (ext_data_oe),
        .ext_be_n     (ext_be_n),
        .ext_we_n     (ext_we_n),
        .ext_oe_n     (ext_oe_n),
        .sel_act      (sel_act),
        .ext_abort_n  (ext_abort_n)
    );

    ebc_selpins #(.NSEL(NSEL)) u_selpins (
        .act  (sel_act),
        .pol  (cfg_sel_pol),
        .pins (ext_sel)
    );

    assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_act));
endmodule

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0, req_half = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        resp_done, resp_err;
    logic [15:0] resp_rdata;
    logic [15:0] cfg_wait = {4'd9, 4'd15, 4'd3, 4'd0};
    logic [3:0]  cfg_ack_mode = 4'b1000;
    logic [3:1]  cfg_sel_pol = 3'b001;
    logic        cfg_narrow = 1'b0;
    logic [21:0] ext_addr;
    logic [15:0] ext_data_o, ext_data_i;
    logic        ext_data_oe, ext_we_n, ext_oe_n, ext_ack_n, ext_abort_n;
    logic [1:0]  ext_be_n;
    logic [3:0]  ext_sel;
    logic        ext_bw8_n, ext_bw8_pull;
    logic        pin_low = 1'b0;

    int nchk = 0, nfail = 0;
    int ack_delay = 2;
    int strobe_cnt = 0;
    logic strobe;

    always #10 clk = ~clk;

    ext_bus_ctrl i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_half(req_half),
        .req_wdata(req_wdata), .resp_done(resp_done), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .cfg_wait(cfg_wait), .cfg_ack_mode(cfg_ack_mode),
        .cfg_sel_pol(cfg_sel_pol), .cfg_narrow(cfg_narrow), .ext_addr(ext_addr),
        .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe), .ext_data_i(ext_data_i),
        .ext_be_n(ext_be_n), .ext_we_n(ext_we_n), .ext_oe_n(ext_oe_n),
        .ext_sel(ext_sel), .ext_ack_n(ext_ack_n), .ext_abort_n(ext_abort_n),
        .ext_bw8_n(ext_bw8_n), .ext_bw8_pull(ext_bw8_pull)
    );

    // external device model: wired width pin, delayed acknowledge, address-derived read data
    function automatic logic [7:0] gb(logic [21:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign ext_bw8_n = ~(pin_low | ext_bw8_pull);
    assign strobe    = ~ext_we_n | ~ext_oe_n;
    assign ext_ack_n = ~(strobe && (strobe_cnt == ack_delay));
    assign ext_data_i = !ext_bw8_n ? {8'hFF, gb(ext_addr)}
                                   : {gb({ext_addr[21:1], 1'b0}), gb({ext_addr[21:1], 1'b1})};

    always_ff @(posedge clk) strobe_cnt <= strobe ? strobe_cnt + 1 : 0;

    typedef struct packed {
        logic [25:0] addr;
        logic        wr;
        logic        hw;
        logic [15:0] wdata;
        logic [1:0]  nsrc;   // 0 wide, 1 pin pulled outside, 2 internal bit
        logic [2:0]  xsel;   // expected window, 4 = rejected
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{26'h0000010, 1'b1, 1'b0, 16'h00AB, 2'd0, 3'd0},
        '{26'h0000020, 1'b0, 1'b1, 16'h0000, 2'd0, 3'd0},
        '{26'h0400011, 1'b1, 1'b0, 16'h0037, 2'd0, 3'd1},
        '{26'h0400014, 1'b0, 1'b0, 16'h0000, 2'd0, 3'd1},
        '{26'h0800040, 1'b1, 1'b1, 16'hBEEF, 2'd1, 3'd2},
        '{26'h0800042, 1'b0, 1'b1, 16'h0000, 2'd2, 3'd2},
        '{26'h0C00005, 1'b0, 1'b0, 16'h0000, 2'd1, 3'd3},
        '{26'h0C00100, 1'b1, 1'b1, 16'h1234, 2'd0, 3'd3},
        '{26'h0C00203, 1'b1, 1'b0, 16'h00C6, 2'd2, 3'd3},
        '{26'h1000000, 1'b0, 1'b1, 16'h0000, 2'd0, 3'd4},
        '{26'h2C00010, 1'b1, 1'b0, 16'h0055, 2'd0, 3'd4},
        '{26'h03FFFFE, 1'b0, 1'b1, 16'h0000, 2'd0, 3'd0}
    };

    // results of the last access
    logic [21:0] ph_addr [2];
    logic [15:0] ph_do   [2];
    logic [1:0]  ph_be   [2];
    logic [3:0]  ph_sel  [2];
    logic        ph_doe  [2];
    logic        ph_oe   [2];
    int          nph, lat;
    logic        r_err, r_abort;
    logic [15:0] r_rdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] selp(input int idx, input logic [3:1] pol);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            if (i == 0) r[i] = !(idx == 0);
            else        r[i] = pol[i] ? (idx == i) : !(idx == i);
        end
        return r;
    endfunction

    task automatic run_access(input logic [25:0] a, input logic wr, input logic hw,
                              input logic [15:0] wd);
        logic prevs = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_half = hw; req_wdata = wd;
        nph = 0; lat = 0; r_err = 1'b0; r_abort = 1'b0; r_rdata = '0;
        for (int n = 1; n <= 400; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (strobe && !prevs && nph < 2) begin
                ph_addr[nph] = ext_addr; ph_do[nph] = ext_data_o; ph_be[nph] = ext_be_n;
                ph_sel[nph] = ext_sel; ph_doe[nph] = ext_data_oe; ph_oe[nph] = ext_oe_n;
                nph++;
            end
            prevs = strobe;
            if (resp_done) begin
                lat = n; r_err = resp_err; r_rdata = resp_rdata; r_abort = !ext_abort_n;
                break;
            end
        end
        if (lat == 0) chk("R6 response timeout", 0, 1);
    endtask

    task automatic run_vec(input vec_t v);
        logic narrow, split, rej;
        int w, xl;
        logic [15:0] exp_rd, act_lane, exp_lane;
        logic [7:0] wb;
        narrow = (v.nsrc != 2'd0);
        rej    = (v.xsel == 3'd4);
        split  = narrow && v.hw && !rej;
        pin_low    = (v.nsrc == 2'd1);
        cfg_narrow = (v.nsrc == 2'd2);
        if (v.xsel == 3'd3) w = ack_delay;
        else if (!rej)      w = int'(cfg_wait[v.xsel*4 +: 4]);
        else                w = 0;
        xl = rej ? 1 : (split ? 2*w + 4 : w + 2);
        run_access(v.addr, v.wr, v.hw, v.wdata);
        chk("R4 width pin pull follows internal bit", ext_bw8_pull, cfg_narrow);
        if (rej) begin
            chk("R2 reject latency", lat, 1);
            chk("R2 reject error", r_err, 1);
            chk("R2 reject no strobe", nph, 0);
            chk("R2 reject select idle", ext_sel, selp(4, cfg_sel_pol));
        end else begin
            chk(split ? "R5 split latency" : (v.xsel == 3'd3 ? "R7 ack latency" : "R6 wait latency"), lat, xl);
            chk("R6 no error", r_err, 0);
            chk(split ? "R5 two byte cycles" : "R12 one cycle", nph, split ? 2 : 1);
            for (int p = 0; p < 2; p++) begin
                if (p < nph) begin
                    chk(split ? "R5 phase address" : "R1 external address", ph_addr[p],
                        v.hw ? {v.addr[21:1], p[0]} : v.addr[21:0]);
                    chk("R9 R1 select pins", ph_sel[p], selp(int'(v.xsel), cfg_sel_pol));
                    chk(narrow ? "R4 narrow byte enables" : "R3 byte enables", ph_be[p],
                        narrow ? 2'b01 : (v.hw ? 2'b00 : (v.addr[0] ? 2'b01 : 2'b10)));
                    chk("R12 drive enable", ph_doe[p], v.wr);
                    chk("R12 output strobe", ph_oe[p], v.wr);
                    if (v.wr) begin
                        wb = (v.hw && p == 0) ? v.wdata[15:8] : v.wdata[7:0];
                        if (narrow) begin
                            act_lane = {8'h00, ph_do[p][7:0]}; exp_lane = {8'h00, wb};
                        end else if (v.hw) begin
                            act_lane = ph_do[p]; exp_lane = v.wdata;
                        end else begin
                            act_lane = {8'h00, v.addr[0] ? ph_do[p][7:0] : ph_do[p][15:8]};
                            exp_lane = {8'h00, wb};
                        end
                        chk(split ? "R5 split write lane" : (narrow ? "R4 narrow write lane" : "R3 write lane"),
                            act_lane, exp_lane);
                    end
                end
            end
            if (!v.wr) begin
                exp_rd = v.hw ? {gb({v.addr[21:1], 1'b0}), gb({v.addr[21:1], 1'b1})}
                              : {8'h00, gb(v.addr[21:0])};
                chk("R11 read data", r_rdata, exp_rd);
            end
        end
        pin_low = 1'b0; cfg_narrow = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 data drive off in reset", ext_data_oe, 0);
        chk("R10 data pins high in reset", ext_data_o, 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle ready", req_ready, 1);
        chk("R10 idle strobes", {ext_we_n, ext_oe_n, ext_abort_n}, 3'b111);
        chk("R10 idle drive", {ext_data_oe, ext_data_o}, {1'b0, 16'hFFFF});
        chk("R10 idle no response", resp_done, 0);
        chk("R9 idle select levels", ext_sel, selp(4, cfg_sel_pol));
        chk("R3 idle byte enables", ext_be_n, 2'b11);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // acknowledge never comes: abort after 256 strobe cycles
        ack_delay = 1000;
        run_access(26'h0C00000, 1'b0, 1'b0, 16'h0);
        chk("R8 abort latency", lat, 257);
        chk("R8 abort error", r_err, 1);
        chk("R8 abort pin low", r_abort, 1);
        @(negedge clk);
        chk("R8 abort pin released", ext_abort_n, 1);
        ack_delay = 0;
        run_access(26'h0C00008, 1'b0, 1'b1, 16'h0);
        chk("R8 R7 recovery latency", lat, 2);
        chk("R8 recovery no error", r_err, 0);
        chk("R11 recovery read data", r_rdata, {gb(22'h000008), gb(22'h000009)});
        ack_delay = 2;

        // polarity reprogrammed
        cfg_sel_pol = 3'b101;
        @(negedge clk);
        chk("R9 idle levels after change", ext_sel, selp(4, cfg_sel_pol));
        run_vec('{26'h0800007, 1'b0, 1'b0, 16'h0, 2'd0, 3'd2});
        run_vec('{26'h0C00006, 1'b1, 1'b0, 16'h0099, 2'd0, 3'd3});

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule